// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches a set of general-purpose ports. Each port holds a snapshot of its pin levels, and that snapshot is the value software reads back from the port. When a pin that is set as an input no longer matches its bit in the snapshot, the port flags a pending change. The block then asks the shared interrupt line to be pulled low. The line is open drain, so it is active low.

The condition is a level, not a latched event. If the pin goes back to its old value, the condition goes away by itself. When a neighbouring bus decoder reads a port, it pulses that port's capture strobe. The strobe reloads the snapshot from the pins, which clears only that port. Pins set as outputs are masked. A pin that changes from output to input while its level differs from the snapshot raises the condition at once.

The comparison uses raw pin levels. Any polarity inversion is applied later, in the read path. In the first clock after reset the snapshots load the current pins, so leaving reset does not cause a spurious interrupt.

Top module: `port_change_irq`

## Requirements
- R1: While reset is asserted, `irq_pull` is 0, `port_pend` is all zero and `snap_val` is all zero. At the first clock edge after reset is released, every snapshot loads the current `pin_lvl`, and `irq_pull` stays 0 for that edge.
- R2: Pin p is set as an input when `pin_is_in[p]` is 1. If any such pin of port k differs from its bit in `snap_val`, `port_pend[k]` goes to 1 in the same cycle, with no clock edge needed.
- R3: When every input pin of a port matches its snapshot bit again, that port's `port_pend` goes back to 0 in the same cycle, without any read.
- R4: If `rd_capture[k]` is 1 at a rising edge, `snap_val[k*8 +: 8]` takes the `pin_lvl` bits of port k from that edge, and the port's pending flag clears.
- R5: A capture strobe on one port leaves the snapshot and the pending flag of every other port unchanged.
- R6: A pin with `pin_is_in` at 0 never makes its port pending, whatever its level.
- R7: If a pin changes from output to input while its level differs from its snapshot bit, its port becomes pending in that same cycle.
- R8: `irq_pull` is the OR of all `port_pend` bits, registered once. It follows that OR with a delay of one clock.
- R9: A capture loads every bit of the port, including the bits of pins set as outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NP*PW (16) | Synchronized pin levels; port k is in bits k*PW +: PW |
| pin_is_in | input | NP*PW (16) | Direction per pin: 1 = input, 0 = output |
| rd_capture | input | NP (2) | Per-port strobe that reloads the snapshot on a read |
| snap_val | output | NP*PW (16) | Snapshot of each port (the input register value) |
| port_pend | output | NP (2) | Per-port pending change flag |
| irq_pull | output | 1 | 1 = drive the open-drain interrupt line low |

## Verification
A wrong snapshot shows up on `snap_val` one edge after the capture strobe that loaded it. It also shows on `port_pend` in that same cycle, because the flag compares the pins against the stored bits. A fault in masking or in keeping the ports separate shows on `port_pend` as soon as the inputs settle. A fault in the merge stage shows on `irq_pull` exactly one edge later. The bench keeps its own model of the snapshots and compares all three outputs in every cycle. Any divergence is therefore caught within one clock of the cause.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  // Count of input-configured bits where the pin level disagrees with the snapshot
  function automatic int unsigned diff_count(input logic [7:0] pin,
                                             input logic [7:0] snap,
                                             input logic [7:0] is_in);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (is_in[i] && (pin[i] != snap[i])) n++;
    end
    return n;
  endfunction

  // A port is pending when at least one watched bit disagrees
  function automatic logic port_mismatch(input logic [7:0] pin,
                                         input logic [7:0] snap,
                                         input logic [7:0] is_in);
    return |((pin ^ snap) & is_in);
  endfunction

endpackage

// File: rtl/pcd_snapshot.sv
module pcd_snapshot #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          primed,
  input  logic          cap,
  input  logic [PW-1:0] pin,
  input  logic [PW-1:0] is_in,
  output logic [PW-1:0] snap,
  output logic          pend
);
  logic          load_now;
  logic [PW-1:0] watched_diff;

  // Load on the priming edge after reset, or on a read capture
  assign load_now = !primed || cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else if (load_now) snap <= pin;
  end

  assign watched_diff = (pin ^ snap) & is_in;
  assign pend         = primed && (|watched_diff);
endmodule

// File: rtl/pcd_irq_merge.sv
module pcd_irq_merge #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pend,
  output logic          irq_pull
);
  logic any_pend;

  assign any_pend = |pend;

  // One register stage removes glitches from the combinational compare
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pull <= 1'b0;
    else        irq_pull <= any_pend;
  end
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int NP = 2,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP*PW-1:0] pin_lvl,
  input  logic [NP*PW-1:0] pin_is_in,
  input  logic [NP-1:0]    rd_capture,
  output logic [NP*PW-1:0] snap_val,
  output logic [NP-1:0]    port_pend,
  output logic             irq_pull
);
  localparam int TOTAL_PINS = NP * PW;

  logic prime_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prime_done <= 1'b0;
    else        prime_done <= 1'b1;
  end

  for (genvar k = 0; k < NP; k++) begin : g_port
    pcd_snapshot #(.PW(PW)) snap_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .primed (prime_done),
      .cap    (rd_capture[k]),
      .pin    (pin_lvl[k*PW +: PW]),
      .is_in  (pin_is_in[k*PW +: PW]),
      .snap   (snap_val[k*PW +: PW]),
      .pend   (port_pend[k])
    );
  end

  pcd_irq_merge #(.NP(NP)) merge_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (port_pend),
    .irq_pull (irq_pull)
  );

  // Width sanity for the packed port vectors
  initial begin
    if (TOTAL_PINS != $bits(pin_lvl)) $error("pin vector width mismatch");
  end
endmodule

// File: rtl/pcd_irq_chk.sv
module pcd_irq_chk #(
  parameter int NP = 2,
  parameter int PW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP*PW-1:0] pin_lvl,
  input logic [NP*PW-1:0] pin_is_in,
  input logic [NP-1:0]    rd_capture,
  input logic [NP*PW-1:0] snap_val,
  input logic [NP-1:0]    port_pend,
  input logic             irq_pull,
  input logic             prime_done
);
  AST_IRQ_QUIET_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !prime_done |-> (!irq_pull && port_pend == '0)); // R1

  AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull == $past(|port_pend)); // R8

  for (genvar k = 0; k < NP; k++) begin : g_chk
    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_capture[k] |=> snap_val[k*PW +: PW] == $past(pin_lvl[k*PW +: PW])); // R4

    AST_OTHER_PORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (prime_done && !rd_capture[k]) |=> $stable(snap_val[k*PW +: PW])); // R5

    AST_OUTPUTS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_is_in[k*PW +: PW] == '0) |-> !port_pend[k]); // R6

    AST_MATCH_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_lvl[k*PW +: PW] == snap_val[k*PW +: PW]) |-> !port_pend[k]); // R3
  end
endmodule

bind port_change_irq pcd_irq_chk #(.NP(NP), .PW(PW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_lvl    (pin_lvl),
  .pin_is_in  (pin_is_in),
  .rd_capture (rd_capture),
  .snap_val   (snap_val),
  .port_pend  (port_pend),
  .irq_pull   (irq_pull),
  .prime_done (prime_done)
);

// File: tb/port_change_irq_tb.sv
module port_change_irq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_lvl = 16'hA5C3;
  logic [15:0] pin_is_in = 16'hFFFF;
  logic [1:0]  rd_capture = 2'b00;
  logic [15:0] snap_val;
  logic [1:0]  port_pend;
  logic        irq_pull;

  int checks = 0;
  int fails  = 0;

  logic [15:0] snap_m = 16'h0000;
  logic        primed_m = 1'b0;
  logic        irq_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_change_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_is_in(pin_is_in),
    .rd_capture(rd_capture), .snap_val(snap_val), .port_pend(port_pend),
    .irq_pull(irq_pull)
  );

  // Expected pending flag of one port, counted bit by bit
  function automatic logic exp_pend1(input logic [7:0] p, input logic [7:0] s,
                                     input logic [7:0] d, input logic pr);
    int hits = 0;
    for (int i = 0; i < 8; i++) if (d[i] == 1'b1 && p[i] !== s[i]) hits++;
    return pr && (hits > 0);
  endfunction

  function automatic logic [1:0] exp_pend(input logic [15:0] p, input logic [15:0] d);
    return {exp_pend1(p[15:8], snap_m[15:8], d[15:8], primed_m),
            exp_pend1(p[7:0],  snap_m[7:0],  d[7:0],  primed_m)};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // One clock: drive at the falling edge, check pending, step the model at the rising edge, check all
  task automatic cyc(input logic [15:0] p, input logic [15:0] d, input logic [1:0] r,
                     input string tag);
    logic [1:0] pend_before;
    @(negedge clk);
    pin_lvl = p; pin_is_in = d; rd_capture = r;
    #1;
    pend_before = exp_pend(p, d);
    chk(tag, "port_pend (same cycle)", {30'd0, port_pend}, {30'd0, pend_before});
    @(posedge clk);
    irq_m = |pend_before;
    if (!primed_m) begin
      snap_m = p;
      primed_m = 1'b1;
    end else begin
      if (r[0]) snap_m[7:0]  = p[7:0];
      if (r[1]) snap_m[15:8] = p[15:8];
    end
    #1;
    chk(tag, "snap_val", {16'd0, snap_val}, {16'd0, snap_m});
    chk(tag, "port_pend (after edge)", {30'd0, port_pend}, {30'd0, exp_pend(p, d)});
    chk(tag, "irq_pull", {31'd0, irq_pull}, {31'd0, irq_m});
  endtask

  initial begin
    void'($urandom(32'h1C0FFEE));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "irq_pull in reset", {31'd0, irq_pull}, 32'd0);
    chk("R1", "port_pend in reset", {30'd0, port_pend}, 32'd0);
    chk("R1", "snap_val in reset", {16'd0, snap_val}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // Priming edge: snapshot takes pins, no interrupt
    cyc(16'hA5C3, 16'hFFFF, 2'b00, "R1");
    // R2: one port-0 pin flips
    cyc(16'hA5CB, 16'hFFFF, 2'b00, "R2");
    cyc(16'hA5CB, 16'hFFFF, 2'b00, "R8");
    // R3: the pin returns, the condition clears without a read
    cyc(16'hA5C3, 16'hFFFF, 2'b00, "R3");
    cyc(16'hA5C3, 16'hFFFF, 2'b00, "R3");
    // Both ports change, then port 0 is read
    cyc(16'hB5C2, 16'hFFFF, 2'b00, "R2");
    cyc(16'hB5C2, 16'hFFFF, 2'b01, "R4");
    cyc(16'hB5C2, 16'hFFFF, 2'b00, "R5");
    cyc(16'hB5C2, 16'hFFFF, 2'b10, "R4");
    cyc(16'hB5C2, 16'hFFFF, 2'b00, "R8");
    // R6: port 0 set to outputs, its pins toggle freely
    cyc(16'hB53D, 16'hFF00, 2'b00, "R6");
    cyc(16'hB5FF, 16'hFF00, 2'b00, "R6");
    // R7: back to inputs with a mismatching level
    cyc(16'hB5FF, 16'hFF0F, 2'b00, "R7");
    cyc(16'hB5FF, 16'hFFFF, 2'b00, "R7");
    // R9: capture while some bits are outputs, snapshot takes them all
    cyc(16'hB566, 16'hFF0F, 2'b01, "R9");
    cyc(16'hB566, 16'hFFFF, 2'b00, "R9");
    // Random mix: sparse pin flips, direction changes, reads
    for (int n = 0; n < 400; n++) begin
      logic [15:0] p;
      logic [15:0] d;
      p = pin_lvl;
      if (($urandom % 3) == 0) p[$urandom % 16] ^= 1'b1;
      d = (($urandom % 8) == 0) ? 16'($urandom) : pin_is_in;
      cyc(p, d, 2'($urandom % 4 == 0 ? $urandom : 0), "R8");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule